// File: doc/BRIEF.md
# Cascadable Reload Down-Counter Timer Bank

This block holds four 8-bit down-counting timers behind a small byte-addressed register port. Software programs a reload value into each timer's base register and then turns the timer on through its mode register. A running timer counts down on every cycle of the main clock. When its count runs out it reloads from the base register and raises a one-cycle underflow pulse. Software can chain neighbouring timers to build a 16-, 24- or 32-bit counter. In a chain the lowest timer is the head and supplies the low byte. Each follower adds one more significant byte. Only the highest timer of the chain reports underflow.

The register port carries one access per cycle with a size of 1, 2 or 4 bytes. Multi-byte values are packed big-endian, so the lowest-numbered timer sits in the most significant byte. Read data and the error flag are registered and appear in the cycle after the access. An access the block cannot honour raises the error flag and leaves every register unchanged.

Top module: `tmr_bank`

## Requirements
- R1: After synchronous reset all mode, base and counter state reads as zero, and `uflow`, `err` and `rdata` are low.
- R2: Each mode byte has these fields:
  - bit 7 enables counting and bit 6 requests a load.
  - bits 1:0 pick the source: 00 counts the main clock, 11 makes the timer a follower of the timer below it, and 01 and 10 never count.
  - bits 5:2 are reserved.

  A mode write is rejected if a reserved bit is set, if bits 7 and 6 are both set, or if it puts timer 0 into follower mode. A rejected write sets `err` and leaves the mode register unchanged.
- R3: The register groups sit at addresses 0x00–0x03 (mode), 0x10–0x13 (base) and 0x20–0x23 (counter), where address bits 1:0 give the timer number. Size codes are 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes.
  - A 2-byte access is legal only at timers 0 and 2. A 4-byte access is legal only at timer 0.
  - Multi-byte data is big-endian: the lowest-numbered timer is in the top byte.
  - Mode registers take only 1-byte writes, and the counter group is read-only.
  - Any other access, including an unmapped address or size code 3, sets `err`, writes nothing and returns zero read data.
- R4: `rdata` and `err` reflect an access in the cycle after it is presented, and `rdata` holds its value until the next read.
- R5: Reading the counter of a timer that is not running returns its base register, including a base value written while the timer was stopped.
- R6: A legal mode write with bit 7 set, source 00 and a non-zero period starts the timer. Counter reads then give the base value N, then N-1, and so on. The first underflow pulse comes N cycles after the write, and pulses repeat every N cycles.
- R7: A base write made while a timer runs does not disturb the running count. The new value is used from the next reload onward.
- R8: A mode write that clears bit 7 stops the timer. No underflow follows, and the counter again reads as the base value.
- R9: Starting a head with followers chained above it gives a period equal to the base bytes concatenated, with the head in the low byte. The underflow pulse appears only on the highest timer of the chain.
- R10: Starting a head whose follower does not have bit 7 set is rejected with `err`, and nothing counts.
- R11: A start whose concatenated period is zero is accepted but does not count, and no underflow occurs.
- R12: Each bit of `uflow` is a registered pulse, one cycle per underflow of the chain that timer closes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock, also the counting clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request this cycle (has priority over a read) |
| rd_en | input | 1 | Read request this cycle |
| addr | input | 8 | Byte address of the access |
| size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| wdata | input | 32 | Write data, right-aligned, big-endian across timers |
| rdata | output | 32 | Registered read data |
| err | output | 1 | One-cycle flag for a rejected access |
| uflow | output | 4 | Per-timer underflow pulses |

## Verification
Wrong count state shows up at the ports in one of two ways. A pulse may land on the wrong cycle or the wrong timer, which is visible within one period of the start. A counter read may disagree with the cycle-exact value expected, which is visible on the next read. A broken chain or borrow path shows up as an underflow pulse on the head instead of the top timer, or as a 16-bit period that is off by a multiple of 256. The bench counts cycle by cycle across that full period. A decode fault shows up one cycle after the access as a missing or unexpected `err`, or as a read-back that differs in the byte lanes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;

  localparam int EN_BIT = 7;
  localparam int LD_BIT = 6;
  localparam logic [1:0] CLK_IO   = 2'b00;
  localparam logic [1:0] CLK_CASC = 2'b11;

  localparam logic [3:0] GRP_MODE = 4'h0;
  localparam logic [3:0] GRP_BASE = 4'h1;
  localparam logic [3:0] GRP_CNT  = 4'h2;

  typedef enum logic [1:0] {
    SZ_1   = 2'd0,
    SZ_2   = 2'd1,
    SZ_4   = 2'd2,
    SZ_BAD = 2'd3
  } acc_sz_e;
endpackage

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_pkg::*;
#(
  parameter int NT = 4
) (
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [1:0]                 size,
  input  logic [BUS_W-1:0]           wdata,
  input  logic [NT-1:0][BYTE_W-1:0]  mode_q,
  input  logic [NT-1:0][BYTE_W-1:0]  base_q,
  input  logic [NT-1:0][BYTE_W-1:0]  view_q,
  output logic [NT-1:0]              mode_we,
  output logic [BYTE_W-1:0]          mode_wd,
  output logic [NT-1:0]              base_we,
  output logic [NT-1:0][BYTE_W-1:0]  base_wd,
  output logic                       start_go,
  output logic [NT-1:0]              chain_ld,
  output logic                       acc_err,
  output logic [BUS_W-1:0]           rd_next
);
  logic [3:0]        grp;
  logic [3:0]        idx;
  int                lo;
  int                nb;
  logic              align_ok;
  logic              grp_ok;
  logic              bad_mode;
  logic              more;
  logic              nz;
  logic [BYTE_W-1:0] v;

  assign grp = addr[ADDR_W-1:4];
  assign idx = addr[3:0];
  assign v   = wdata[BYTE_W-1:0];

  always_comb begin
    lo = int'(idx);
    case (acc_sz_e'(size))
      SZ_1:    nb = 1;
      SZ_2:    nb = 2;
      SZ_4:    nb = 4;
      default: nb = 0;
    endcase
    align_ok = 1'b0;
    if (nb > 0) align_ok = ((lo % nb) == 0) && (lo + nb <= NT);
    grp_ok = (grp == GRP_MODE) || (grp == GRP_BASE) || (grp == GRP_CNT);
  end

  always_comb begin
    mode_we  = '0;
    mode_wd  = v;
    base_we  = '0;
    base_wd  = '0;
    start_go = 1'b0;
    chain_ld = '0;
    acc_err  = 1'b0;
    rd_next  = '0;
    bad_mode = 1'b0;
    more     = 1'b0;
    nz       = 1'b0;
    if (wr_en) begin
      if (!align_ok || !grp_ok || grp == GRP_CNT) begin
        acc_err = 1'b1;
      end else if (grp == GRP_BASE) begin
        for (int j = 0; j < NT; j++) begin
          if (j >= lo && j < lo + nb) begin
            base_we[j] = 1'b1;
            base_wd[j] = wdata[BYTE_W*(nb-1-(j-lo)) +: BYTE_W];
          end
        end
      end else if (nb != 1) begin
        acc_err = 1'b1;
      end else begin
        bad_mode = (v[5:2] != 4'd0) || (v[EN_BIT] && v[LD_BIT]) ||
                   (v[1:0] == CLK_CASC && lo == 0);
        if (v[EN_BIT] && v[1:0] == CLK_IO) begin
          more = 1'b1;
          for (int j = 0; j < NT; j++) begin
            if (j == lo) begin
              chain_ld[j] = 1'b1;
              nz = nz | (base_q[j] != '0);
            end else if (j > lo && more) begin
              if (mode_q[j][1:0] == CLK_CASC) begin
                if (!mode_q[j][EN_BIT]) bad_mode = 1'b1;
                chain_ld[j] = 1'b1;
                nz = nz | (base_q[j] != '0);
              end else begin
                more = 1'b0;
              end
            end
          end
        end
        if (bad_mode) begin
          acc_err  = 1'b1;
          chain_ld = '0;
        end else begin
          mode_we[lo] = 1'b1;
          start_go = v[EN_BIT] && (v[1:0] == CLK_IO) && nz;
          if (!start_go) chain_ld = '0;
        end
      end
    end else if (rd_en) begin
      if (!align_ok || !grp_ok) begin
        acc_err = 1'b1;
      end else begin
        for (int j = 0; j < NT; j++) begin
          if (j >= lo && j < lo + nb) begin
            if (grp == GRP_MODE)
              rd_next[BYTE_W*(nb-1-(j-lo)) +: BYTE_W] = mode_q[j];
            else if (grp == GRP_BASE)
              rd_next[BYTE_W*(nb-1-(j-lo)) +: BYTE_W] = base_q[j];
            else
              rd_next[BYTE_W*(nb-1-(j-lo)) +: BYTE_W] = view_q[j];
          end
        end
      end
    end
  end
endmodule

// File: rtl/tmr_chain.sv
module tmr_chain
  import tmr_pkg::*;
#(
  parameter int NT = 4
) (
  input  logic [NT-1:0]             is_casc,
  input  logic [NT-1:0]             active_q,
  input  logic [NT-1:0][BYTE_W-1:0] cnt_q,
  output logic [NT-1:0]             run,
  output logic [NT-1:0]             dec,
  output logic [NT-1:0]             reload,
  output logic [NT-1:0]             fire
);
  logic [NT-1:0] head;
  logic [NT-1:0] last;
  logic [NT-1:0] one_upto;

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      head[i] = (i == 0) || !is_casc[i];
      last[i] = (i == NT - 1) ? 1'b1 : !is_casc[(i + 1) % NT];
    end
  end

  // walk upward: run flag, borrow into each byte, chain-value-equals-one
  always_comb begin
    run      = '0;
    dec      = '0;
    one_upto = '0;
    for (int i = 0; i < NT; i++) begin
      if (head[i]) begin
        run[i]      = active_q[i];
        dec[i]      = 1'b1;
        one_upto[i] = (cnt_q[i] == BYTE_W'(1));
      end else begin
        run[i]      = run[i-1];
        dec[i]      = dec[i-1] && (cnt_q[i-1] == '0);
        one_upto[i] = one_upto[i-1] && (cnt_q[i] == '0);
      end
    end
  end

  // walk downward: the top of a chain decides reload for all its bytes
  always_comb begin
    fire   = '0;
    reload = '0;
    for (int i = NT - 1; i >= 0; i--) begin
      fire[i] = last[i] && run[i] && one_upto[i];
      if (last[i]) reload[i] = fire[i];
      else         reload[i] = reload[i+1];
    end
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_we,
  input  logic [BYTE_W-1:0] mode_wd,
  input  logic              go,
  input  logic              base_we,
  input  logic [BYTE_W-1:0] base_wd,
  input  logic              start_ld,
  input  logic              run,
  input  logic              dec,
  input  logic              reload,
  input  logic              fire,
  output logic [BYTE_W-1:0] mode_q,
  output logic [BYTE_W-1:0] base_q,
  output logic [BYTE_W-1:0] cnt_q,
  output logic              active_q,
  output logic              uflow_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      base_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      uflow_q  <= 1'b0;
    end else begin
      if (mode_we) begin
        mode_q   <= mode_wd;
        active_q <= go;
      end
      if (base_we) base_q <= base_wd;
      if (start_ld)                cnt_q <= base_q;
      else if (run && reload)      cnt_q <= base_q;
      else if (run && dec)         cnt_q <= cnt_q - BYTE_W'(1);
      uflow_q <= fire;
    end
  end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        addr,
  input  logic [1:0]        size,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              err,
  output logic [NT-1:0]     uflow
);
  logic [NT-1:0][BYTE_W-1:0] mode_q, base_q, cnt_q, view_q, base_wd;
  logic [NT-1:0]             mode_we, base_we, chain_ld, active_q;
  logic [NT-1:0]             is_casc, run, dec, reload, fire;
  logic [BYTE_W-1:0]         mode_wd;
  logic                      start_go, acc_err;
  logic [BUS_W-1:0]          rd_next;
  logic [BUS_W-1:0]          rdata_q;
  logic                      err_q;

  tmr_regif #(.NT(NT)) u_regif (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .size(size), .wdata(wdata),
    .mode_q(mode_q), .base_q(base_q), .view_q(view_q),
    .mode_we(mode_we), .mode_wd(mode_wd), .base_we(base_we), .base_wd(base_wd),
    .start_go(start_go), .chain_ld(chain_ld), .acc_err(acc_err), .rd_next(rd_next)
  );

  tmr_chain #(.NT(NT)) u_chain (
    .is_casc(is_casc), .active_q(active_q), .cnt_q(cnt_q),
    .run(run), .dec(dec), .reload(reload), .fire(fire)
  );

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    assign is_casc[g] = (mode_q[g][1:0] == CLK_CASC);
    assign view_q[g]  = run[g] ? cnt_q[g] : base_q[g];

    tmr_unit u_unit (
      .clk(clk), .rst(rst),
      .mode_we(mode_we[g]), .mode_wd(mode_wd), .go(start_go),
      .base_we(base_we[g]), .base_wd(base_wd[g]),
      .start_ld(chain_ld[g]),
      .run(run[g]), .dec(dec[g]), .reload(reload[g]), .fire(fire[g]),
      .mode_q(mode_q[g]), .base_q(base_q[g]), .cnt_q(cnt_q[g]),
      .active_q(active_q[g]), .uflow_q(uflow[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= acc_err;
      if (rd_en && !wr_en) rdata_q <= rd_next;
    end
  end

  assign rdata = rdata_q;
  assign err   = err_q;
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
  import tmr_pkg::*;
#(
  parameter int NT = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        addr,
  input logic [1:0]        size,
  input logic [7:0]        wbyte,
  input logic              err,
  input logic [NT-1:0]     uflow,
  input logic [NT-1:0]     is_casc,
  input logic [7:0]        mode0
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!err && uflow == '0));

  // R4
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(wr_en || rd_en));

  // R3
  cnt_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr[7:4] == GRP_CNT) |=> err);

  // R2
  en_ld_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 8'h00 && size == 2'd0 && wbyte[7:6] == 2'b11)
      |=> (err && mode0 == $past(mode0)));

  // R9
  for (genvar i = 0; i < NT - 1; i++) begin : g_top
    top_only_chk: assert property (@(posedge clk) disable iff (rst)
      uflow[i] |-> !$past(is_casc[i+1]));
  end
endmodule

bind tmr_bank tmr_bank_chk #(.NT(NT)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .size(size), .wbyte(wdata[7:0]), .err(err), .uflow(uflow),
  .is_casc(is_casc), .mode0(mode_q[0])
);

// File: tb/sim_tmr_bank.sv
module sim_tmr_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic [3:0]  uflow;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_bank #(.NT(4)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .size(size), .wdata(wdata), .rdata(rdata), .err(err), .uflow(uflow)
  );

  // op(1) size(2) addr(8) wdata(32) expected rdata(32) expected err(1)
  localparam int NV = 23;
  localparam logic [75:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'h10, 32'h000000AA, 32'h0,        1'b0},
    {1'b1, 2'd0, 8'h10, 32'h0,        32'h000000AA, 1'b0},
    {1'b0, 2'd1, 8'h12, 32'h0000BBCC, 32'h0,        1'b0},
    {1'b1, 2'd2, 8'h10, 32'h0,        32'hAA00BBCC, 1'b0},
    {1'b1, 2'd0, 8'h22, 32'h0,        32'h000000BB, 1'b0},
    {1'b0, 2'd1, 8'h11, 32'h0000FFFF, 32'h0,        1'b1},
    {1'b0, 2'd0, 8'h20, 32'h00000055, 32'h0,        1'b1},
    {1'b0, 2'd1, 8'h00, 32'h00008080, 32'h0,        1'b1},
    {1'b0, 2'd0, 8'h00, 32'h000000C0, 32'h0,        1'b1},
    {1'b0, 2'd0, 8'h01, 32'h00000004, 32'h0,        1'b1},
    {1'b0, 2'd0, 8'h00, 32'h00000003, 32'h0,        1'b1},
    {1'b1, 2'd2, 8'h00, 32'h0,        32'h00000000, 1'b0},
    {1'b0, 2'd0, 8'h40, 32'h00000011, 32'h0,        1'b1},
    {1'b1, 2'd0, 8'h04, 32'h0,        32'h00000000, 1'b1},
    {1'b0, 2'd2, 8'h10, 32'h11223344, 32'h0,        1'b0},
    {1'b1, 2'd2, 8'h10, 32'h0,        32'h11223344, 1'b0},
    {1'b1, 2'd1, 8'h22, 32'h0,        32'h00003344, 1'b0},
    {1'b0, 2'd0, 8'h03, 32'h00000043, 32'h0,        1'b0},
    {1'b1, 2'd2, 8'h00, 32'h0,        32'h00000043, 1'b0},
    {1'b1, 2'd1, 8'h01, 32'h0,        32'h00000000, 1'b1},
    {1'b0, 2'd0, 8'h02, 32'h00000001, 32'h0,        1'b0},
    {1'b1, 2'd0, 8'h02, 32'h0,        32'h00000001, 1'b0},
    {1'b0, 2'd3, 8'h10, 32'h00000000, 32'h0,        1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus(input logic op, input logic [1:0] sz, input logic [7:0] a,
                     input logic [31:0] d);
    wr_en = !op; rd_en = op; size = sz; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL R6 watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 uflow", {28'd0, uflow}, 32'd0);
    chk("R1 err", {31'd0, err}, 32'd0);
    chk("R1 rdata", rdata, 32'd0);
    bus(1'b1, 2'd2, 8'h20, 0); chk("R1 counters", rdata, 32'd0);
    bus(1'b1, 2'd2, 8'h00, 0); chk("R1 modes", rdata, 32'd0);

    // R3 table: access sizes, packing, decode errors (R2, R5 entries inside)
    for (int i = 0; i < NV; i++) begin
      bus(VEC[i][75], VEC[i][74:73], VEC[i][72:65], VEC[i][64:33]);
      chk($sformatf("R3 table %0d err", i), {31'd0, err}, {31'd0, VEC[i][0]});
      if (VEC[i][75]) chk($sformatf("R4 table %0d rdata", i), rdata, VEC[i][32:1]);
    end

    // R6 single timer, counter reads and first pulse
    do_reset();
    bus(1'b0, 2'd0, 8'h10, 32'd3);
    bus(1'b0, 2'd0, 8'h00, 32'h80);
    bus(1'b1, 2'd0, 8'h20, 0); chk("R6 cnt read 1", rdata, 32'd3);
    bus(1'b1, 2'd0, 8'h20, 0); chk("R6 cnt read 2", rdata, 32'd2);
    bus(1'b1, 2'd0, 8'h20, 0); chk("R6 cnt read 3", rdata, 32'd1);
    chk("R6 pulse at N", {28'd0, uflow}, 32'd1);
    bus(1'b1, 2'd0, 8'h20, 0); chk("R6 reload value", rdata, 32'd3);
    chk("R12 pulse width", {28'd0, uflow}, 32'd0);

    // R7 base change while running, then R8 stop
    do_reset();
    bus(1'b0, 2'd0, 8'h10, 32'd3);
    bus(1'b0, 2'd0, 8'h00, 32'h80);      // k = 0
    bus(1'b0, 2'd0, 8'h10, 32'd5);       // k = 1
    for (int k = 2; k <= 9; k++) begin
      step();
      chk($sformatf("R7 k=%0d", k), {28'd0, uflow}, (k == 3 || k == 8) ? 32'd1 : 32'd0);
    end
    bus(1'b0, 2'd0, 8'h00, 32'h00);      // k = 10
    for (int k = 11; k <= 20; k++) begin
      step();
      chk($sformatf("R8 k=%0d", k), {28'd0, uflow}, 32'd0);
    end
    bus(1'b1, 2'd0, 8'h20, 0); chk("R8 stopped view", rdata, 32'd5);

    // R9 16-bit chain, period 0x0102
    do_reset();
    bus(1'b0, 2'd1, 8'h10, 32'h0201);
    bus(1'b1, 2'd1, 8'h20, 0); chk("R5 stopped pair", rdata, 32'h0201);
    bus(1'b0, 2'd0, 8'h01, 32'h83);
    bus(1'b1, 2'd0, 8'h01, 0); chk("R2 follower mode", rdata, 32'h83);
    bus(1'b0, 2'd0, 8'h00, 32'h80);      // k = 0
    for (int k = 1; k <= 260; k++) begin
      step();
      chk($sformatf("R9 k=%0d", k), {28'd0, uflow}, (k == 258) ? 32'd2 : 32'd0);
    end

    // R9 32-bit chain, period 1: top timer pulses every cycle
    do_reset();
    bus(1'b0, 2'd2, 8'h10, 32'h01000000);
    bus(1'b0, 2'd0, 8'h03, 32'h83);
    bus(1'b0, 2'd0, 8'h02, 32'h83);
    bus(1'b0, 2'd0, 8'h01, 32'h83);
    bus(1'b0, 2'd0, 8'h00, 32'h80);
    for (int k = 1; k <= 3; k++) begin
      step();
      chk($sformatf("R9 wide k=%0d", k), {28'd0, uflow}, 32'h8);
    end

    // R10 follower without enable
    do_reset();
    bus(1'b0, 2'd1, 8'h10, 32'h0101);
    bus(1'b0, 2'd0, 8'h01, 32'h03);
    chk("R2 follower no-en accepted", {31'd0, err}, 32'd0);
    bus(1'b0, 2'd0, 8'h00, 32'h80);
    chk("R10 start rejected", {31'd0, err}, 32'd1);
    bus(1'b1, 2'd0, 8'h00, 0); chk("R10 mode unchanged", rdata, 32'd0);
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R10 no pulse", {28'd0, uflow}, 32'd0);
    end

    // R11 zero period, R5 base written while stopped
    do_reset();
    bus(1'b0, 2'd0, 8'h00, 32'h80);
    chk("R11 accepted", {31'd0, err}, 32'd0);
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R11 no pulse", {28'd0, uflow}, 32'd0);
    end
    bus(1'b1, 2'd0, 8'h20, 0); chk("R11 counter", rdata, 32'd0);
    bus(1'b0, 2'd0, 8'h10, 32'd2);
    bus(1'b1, 2'd0, 8'h20, 0); chk("R5 base shows in counter", rdata, 32'd2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule